// File: doc/BRIEF.md
# Gated Sample-Pacing Rate Divider

The block is a down-counting divide-by-N timer that paces sampling. It runs on a single system clock and moves only on a count tick. A select bit picks that tick from one of two prescaled strobes, a fast one and a slow one, which arrive from outside the block at a 10:1 rate ratio. From the programmed divisor N it produces a pulse once every N ticks. The pulse stays high for exactly one tick period.

A set of one-cycle command strobes controls the counter:

- **Load** stores a new divisor and restarts the count from it.
- **Clear** restarts the count from the stored divisor.
- **Enable** and **disable** start and stop counting.
- **Gate on** and **gate off** decide whether an external gate input also has to be high for counting to happen.
- **Latch** copies the live count into a read register, so software-facing logic can read it.

The external gate passes through a synchronizer before the counter uses it. The latched value does not change until the next latch strobe.

Top module: `pace_divider`

## Requirements
- R1: After reset, `pulse_out` is 0 and `count_rd` is 0. Counting is off, the gate is off, and both the stored divisor and the count are 2, so a latch taken with no other command returns 2.
- R2: `pulse_out` rises on the counting tick that brings the count to 0. It falls on the next counting tick, so it is high for exactly one tick period.
- R3: When a counting tick arrives with the count at 0, the count reloads to divisor−1. In steady running, rising edges of `pulse_out` are therefore exactly N counting ticks apart. This holds for N = 2 as well.
- R4: `rate_sel` = 0 takes `tick_fast` as the count tick. `rate_sel` = 1 takes `tick_slow`.
- R5: `cmd_load` stores `div_in` and sets the count to it on the same edge, and `pulse_out` drops. A `div_in` below 2 is stored as 2. A load while running takes effect immediately.
- R6: After `cmd_disable`, the count and `pulse_out` hold their values. `cmd_enable` resumes counting. When both strobes arrive in one cycle, disable wins.
- R7: With the gate on, ticks advance the count only while `gate_in`, delayed by a 2-flop synchronizer, is 1. With the gate off, the counter runs freely whatever `gate_in` is. When both gate strobes arrive in one cycle, gate off wins.
- R8: `cmd_clear` sets the count to the stored divisor and drops `pulse_out`. When load and clear arrive in one cycle, load wins.
- R9: `cmd_latch` copies the count present before that edge into `count_rd`. `count_rd` does not change on any cycle without a latch strobe.
- R10: The full 24-bit divisor 2^24−1 loads and counts down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_fast | input | 1 | Fast prescaled tick strobe, one clock wide |
| tick_slow | input | 1 | Slow prescaled tick strobe (one tenth of the fast rate) |
| rate_sel | input | 1 | 0 selects fast tick, 1 selects slow tick |
| div_in | input | CNT_W | Divisor value captured by `cmd_load` |
| cmd_load | input | 1 | Load divisor and restart count |
| cmd_clear | input | 1 | Restart count from stored divisor |
| cmd_enable | input | 1 | Start counting |
| cmd_disable | input | 1 | Stop counting |
| cmd_gate_on | input | 1 | Require external gate for counting |
| cmd_gate_off | input | 1 | Ignore external gate |
| cmd_latch | input | 1 | Copy live count into `count_rd` |
| gate_in | input | 1 | Asynchronous external gate |
| pulse_out | output | 1 | Rate pulse, one tick period wide |
| count_rd | output | CNT_W | Latched count |

## Verification
The bench builds the block with its default parameters: a 24-bit count and a 2-flop synchronizer. The tick strobes are made in the bench, at a fast period of 2 clocks and a slow period of 20 clocks. Small divisors then give exact, short pulse periods for both rate selects, with the gate both active and inactive. Because the count is the full 24 bits, the top divisor 2^24−1 can be loaded. It is checked through latched readback rather than by waiting for a full period.

// File: rtl/pace_div_pkg.sv
// Shared definitions for the pace divider.
// Assumes: divisors below MIN_DIVISOR are never used as a period.
package pace_div_pkg;
    localparam int MIN_DIVISOR = 2;

    // Run-mode flags held by the mode controller
    typedef struct packed {
        logic run;      // counting enabled
        logic gate_en;  // external gate must be high to count
    } pd_mode_t;
endpackage

// File: rtl/pd_gate_sync.sv
// Multi-stage synchronizer for the asynchronous external gate.
// Assumes: STAGES >= 2; output lags input by STAGES clock edges.
module pd_gate_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw gate through the flop chain
    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= 1'b0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/pd_mode_ctrl.sv
// Holds run and gate-enable flags set and cleared by command strobes.
// Assumes: strobes are one clock wide; the "off" strobe wins a tie.
module pd_mode_ctrl
    import pace_div_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cmd_enable,
    input  logic     cmd_disable,
    input  logic     cmd_gate_on,
    input  logic     cmd_gate_off,
    output pd_mode_t mode_o
);
    pd_mode_t mode_q;

    // Update the flags; disable and gate-off take priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else begin
            if (cmd_disable)      mode_q.run <= 1'b0;
            else if (cmd_enable)  mode_q.run <= 1'b1;
            if (cmd_gate_off)     mode_q.gate_en <= 1'b0;
            else if (cmd_gate_on) mode_q.gate_en <= 1'b1;
        end
    end

    assign mode_o = mode_q;

    AST_DISABLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_disable |=> !mode_o.run); // R6
    AST_GATE_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_gate_off |=> !mode_o.gate_en); // R7
endmodule

// File: rtl/pd_down_counter.sv
// Divide-by-N down counter with divisor store and zero pulse.
// Assumes: adv is a one-clock strobe; load beats clear beats adv.
module pd_down_counter
    import pace_div_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             cmd_load,
    input  logic             cmd_clear,
    input  logic [CNT_W-1:0] div_in,
    output logic [CNT_W-1:0] count_o,
    output logic             pulse_o
);
    localparam logic [CNT_W-1:0] DIV_FLOOR = CNT_W'(MIN_DIVISOR);
    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

    logic [CNT_W-1:0] div_q, count_q, div_clamped;
    logic             pulse_q;

    // Replace divisors that are too small by the floor value
    always_comb begin
        div_clamped = (div_in < DIV_FLOOR) ? DIV_FLOOR : div_in;
    end

    // Divisor store, count and zero pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q   <= DIV_FLOOR;
            count_q <= DIV_FLOOR;
            pulse_q <= 1'b0;
        end else if (cmd_load) begin
            div_q   <= div_clamped;
            count_q <= div_clamped;
            pulse_q <= 1'b0;
        end else if (cmd_clear) begin
            count_q <= div_q;
            pulse_q <= 1'b0;
        end else if (adv) begin
            if (count_q == '0) begin
                count_q <= div_q - ONE;
                pulse_q <= 1'b0;
            end else begin
                count_q <= count_q - ONE;
                pulse_q <= (count_q == ONE);
            end
        end
    end

    assign count_o = count_q;
    assign pulse_o = pulse_q;

    AST_PULSE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> (count_q == '0)); // R2
    AST_PULSE_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_q && adv && !cmd_load && !cmd_clear) |=> !pulse_q); // R2
    AST_RELOAD_AFTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && count_q == '0 && !cmd_load && !cmd_clear) |=> (count_q == $past(div_q) - ONE)); // R3
    AST_DIV_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        div_q >= DIV_FLOOR); // R5
    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !cmd_load && !cmd_clear) |=> ($stable(count_q) && $stable(pulse_q))); // R6
    AST_CLEAR_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_clear && !cmd_load) |=> (count_q == $past(div_q) && !pulse_q)); // R8
endmodule

// File: rtl/pace_divider.sv
// Top of the gated sample-pacing divider: tick select, gating,
// counter and latched count readback.
// Assumes: tick inputs are one-clock strobes in the clk domain;
// gate_in is asynchronous.
module pace_divider
    import pace_div_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_fast,
    input  logic             tick_slow,
    input  logic             rate_sel,
    input  logic [CNT_W-1:0] div_in,
    input  logic             cmd_load,
    input  logic             cmd_clear,
    input  logic             cmd_enable,
    input  logic             cmd_disable,
    input  logic             cmd_gate_on,
    input  logic             cmd_gate_off,
    input  logic             cmd_latch,
    input  logic             gate_in,
    output logic             pulse_out,
    output logic [CNT_W-1:0] count_rd
);
    pd_mode_t         mode;
    logic             gate_s, tick_sel, adv;
    logic [CNT_W-1:0] count_live, rd_q;

    pd_gate_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .async_in(gate_in), .sync_out(gate_s)
    );

    pd_mode_ctrl i_mode (
        .clk(clk), .rst_n(rst_n),
        .cmd_enable(cmd_enable), .cmd_disable(cmd_disable),
        .cmd_gate_on(cmd_gate_on), .cmd_gate_off(cmd_gate_off),
        .mode_o(mode)
    );

    // Pick the count tick and qualify it with run and gate state
    always_comb begin
        tick_sel = rate_sel ? tick_slow : tick_fast;
        adv      = tick_sel && mode.run && (!mode.gate_en || gate_s);
    end

    pd_down_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk(clk), .rst_n(rst_n), .adv(adv),
        .cmd_load(cmd_load), .cmd_clear(cmd_clear), .div_in(div_in),
        .count_o(count_live), .pulse_o(pulse_out)
    );

    // Capture the live count for readback on a latch strobe
    always_ff @(posedge clk) begin
        if (!rst_n)         rd_q <= '0;
        else if (cmd_latch) rd_q <= count_live;
    end

    assign count_rd = rd_q;

    AST_READ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_latch |=> $stable(count_rd)); // R9
    AST_READ_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_latch |=> (count_rd == $past(count_live))); // R9
endmodule

// File: tb/test_pace_divider.sv
module test_pace_divider;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 24;
    localparam int P_FAST     = 2;
    localparam int P_SLOW     = 20;
    localparam logic [6:0] C_LD = 7'b0000001, C_CLR = 7'b0000010,
        C_EN = 7'b0000100, C_DIS = 7'b0001000, C_GON = 7'b0010000,
        C_GOFF = 7'b0100000, C_LAT = 7'b1000000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic tick_fast = 1'b0, tick_slow = 1'b0, rate_sel = 1'b0, gate_in = 1'b0;
    logic [CNT_W-1:0] div_in = '0;
    logic cmd_load = 0, cmd_clear = 0, cmd_enable = 0, cmd_disable = 0;
    logic cmd_gate_on = 0, cmd_gate_off = 0, cmd_latch = 0;
    logic pulse_out;
    logic [CNT_W-1:0] count_rd;
    int checks = 0, errors = 0, cyc = 0, tick_cnt = 0;

    pace_divider #(.CNT_W(CNT_W), .SYNC_STAGES(2)) i_pace_divider (
        .clk(clk), .rst_n(rst_n), .tick_fast(tick_fast), .tick_slow(tick_slow),
        .rate_sel(rate_sel), .div_in(div_in), .cmd_load(cmd_load),
        .cmd_clear(cmd_clear), .cmd_enable(cmd_enable), .cmd_disable(cmd_disable),
        .cmd_gate_on(cmd_gate_on), .cmd_gate_off(cmd_gate_off),
        .cmd_latch(cmd_latch), .gate_in(gate_in), .pulse_out(pulse_out),
        .count_rd(count_rd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Free-running prescaled tick strobes
    always @(posedge clk) begin
        tick_cnt  <= (tick_cnt == P_SLOW - 1) ? 0 : tick_cnt + 1;
        tick_fast <= (tick_cnt % P_FAST) == 0;
        tick_slow <= (tick_cnt == 0);
    end

    // Watchdog
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog R1..R10 hung: actual=%0d cycles expected<150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe(input logic [6:0] m);
        {cmd_latch, cmd_gate_off, cmd_gate_on, cmd_disable, cmd_enable, cmd_clear, cmd_load} = m;
        @(negedge clk);
        {cmd_latch, cmd_gate_off, cmd_gate_on, cmd_disable, cmd_enable, cmd_clear, cmd_load} = '0;
    endtask

    task automatic load(input logic [CNT_W-1:0] d);
        div_in = d;
        strobe(C_LD);
    endtask

    // Latch and return the count (register visible after the strobe cycle)
    task automatic read(output logic [CNT_W-1:0] v);
        strobe(C_LAT);
        v = count_rd;
    endtask

    // Measure one full period and high time between pulse rising edges
    task automatic measure(input int exp_per, input int exp_hi, input string req);
        int c = 0, per = 0, hi = 0;
        logic prev = pulse_out, rise = 1'b0;
        do begin
            @(negedge clk); c++;
            rise = pulse_out && !prev; prev = pulse_out;
        end while (!rise && c < 20000);
        do begin
            @(negedge clk); per++;
            if (pulse_out) hi++;
            rise = pulse_out && !prev; prev = pulse_out;
        end while (!rise && per < 20000);
        check(per == exp_per, {req, " period"}, per, exp_per);
        check(hi == exp_hi, "R2 pulse width", hi, exp_hi);
    endtask

    task automatic t_reset();
        logic [CNT_W-1:0] v;
        check(pulse_out == 1'b0, "R1 pulse after reset", pulse_out, 0);
        check(count_rd == '0, "R1 count_rd after reset", count_rd, 0);
        idle(30);
        read(v);
        check(v == 2, "R1 idle count stays at reset divisor", v, 2);
    endtask

    task automatic t_period(input int n, input bit sel, input string req);
        strobe(C_DIS);
        rate_sel = sel;
        load(CNT_W'(n));
        strobe(C_EN);
        measure(n * (sel ? P_SLOW : P_FAST), sel ? P_SLOW : P_FAST, req);
    endtask

    task automatic t_clamp();
        logic [CNT_W-1:0] v;
        strobe(C_DIS);
        rate_sel = 1'b0;
        load('0);
        read(v);
        check(v == 2, "R5 divisor 0 stored as 2", v, 2);
        load(CNT_W'(1));
        read(v);
        check(v == 2, "R5 divisor 1 stored as 2", v, 2);
        strobe(C_EN);
        measure(2 * P_FAST, P_FAST, "R5 clamped divisor");
        load(CNT_W'(13));
        load(CNT_W'(3));
        measure(3 * P_FAST, P_FAST, "R5 load while running");
    endtask

    task automatic t_enable();
        logic [CNT_W-1:0] a, b;
        strobe(C_DIS);
        rate_sel = 1'b0;
        load(CNT_W'(9));
        strobe(C_EN | C_DIS);
        idle(60);
        read(a);
        check(a == 9, "R6 disable wins over enable", a, 9);
        strobe(C_EN);
        idle(31);
        strobe(C_DIS);
        read(a);
        idle(60);
        read(b);
        check(b == a, "R6 count holds while disabled", b, a);
        check(a != 9, "R6 enable resumes counting", a, 9);
    endtask

    task automatic t_gate();
        logic [CNT_W-1:0] a, b;
        strobe(C_DIS);
        rate_sel = 1'b0;
        gate_in = 1'b0;
        load(CNT_W'(6));
        strobe(C_GON);
        strobe(C_EN);
        idle(50);
        read(a);
        check(a == 6, "R7 gate low blocks counting", a, 6);
        check(pulse_out == 1'b0, "R7 no pulse while gated", pulse_out, 0);
        gate_in = 1'b1;
        measure(6 * P_FAST, P_FAST, "R7 gate high counts");
        gate_in = 1'b0;
        idle(10);
        read(a);
        idle(40);
        read(b);
        check(b == a, "R7 gate dropped freezes count", b, a);
        strobe(C_GON | C_GOFF);
        measure(6 * P_FAST, P_FAST, "R7 gate off wins, free run");
    endtask

    task automatic t_clear();
        logic [CNT_W-1:0] v;
        int c = 0;
        strobe(C_DIS);
        rate_sel = 1'b0;
        load(CNT_W'(4));
        strobe(C_EN);
        while (!pulse_out && c < 1000) begin @(negedge clk); c++; end
        check(pulse_out == 1'b1, "R2 pulse reached before clear", pulse_out, 1);
        strobe(C_DIS | C_CLR);
        check(pulse_out == 1'b0, "R8 clear drops pulse", pulse_out, 0);
        read(v);
        check(v == 4, "R8 clear restores divisor", v, 4);
        div_in = CNT_W'(11);
        strobe(C_LD | C_CLR);
        read(v);
        check(v == 11, "R8 load wins over clear", v, 11);
    endtask

    task automatic t_max();
        logic [CNT_W-1:0] a, b, c;
        strobe(C_DIS);
        rate_sel = 1'b0;
        load('1);
        read(a);
        check(a == 24'hFFFFFF, "R10 full divisor loads", a, 24'hFFFFFF);
        strobe(C_EN);
        idle(100);
        read(b);
        check(b < a && b >= a - 60, "R10 full divisor counts down", b, a - 51);
        idle(100);
        c = count_rd;
        check(c == b, "R9 count_rd holds without latch", c, b);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_period(2, 1'b0, "R3 min divisor fast");
        t_period(5, 1'b0, "R4 fast tick N=5");
        t_period(3, 1'b1, "R4 slow tick N=3");
        t_period(13, 1'b1, "R3 slow tick N=13");
        t_clamp();
        t_enable();
        t_gate();
        t_clear();
        t_max();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule